// File: doc/BRIEF.md
# Sleep-Mode Entry/Exit Controller

This controller sequences a memory block into and out of a low-power sleep state. The sleep request arrives with no fixed relation to the clock. It is synchronized first, and then the controller steps through a fixed entry phase, a sleep phase, an exit phase and a recovery phase before it returns to normal operation. From the start of entry until recovery has finished, the controller blocks every access. Nothing can reach the storage array while it sleeps, so its contents stay untouched.

The controller also watches the chip-select input. The device must be deselected when entry begins and throughout the recovery window. If the chip is selected at either of those times, a one-cycle violation pulse is raised. Outside those two windows, a select during entry, sleep or exit is simply blocked and is not reported.

States, in order: `ST_AWAKE` (normal operation), `ST_ENTER` (entry countdown), `ST_ASLEEP` (sleeping), `ST_EXIT` (exit countdown), `ST_RECOVER` (recovery countdown). Transitions: awake→enter when the synchronized request is high; enter→asleep when the entry count ends; asleep→exit when the synchronized request is low; exit→recover when the exit count ends; recover→awake when the recovery count ends.

Top module: `slp_ctrl`

## Requirements
- R1: Out of reset, `access_ok` is 1, and `sleep_active` and `violation` are 0.
- R2: `sleep_req` passes through a two-flop synchronizer, so `access_ok` falls right after the third rising clock edge that follows a rise of `sleep_req`.
- R3: `sleep_active` rises exactly ENTRY_CYCLES (default 2) clock edges after `access_ok` falls.
- R4: After `sleep_req` is released, `sleep_active` falls right after the third rising clock edge.
- R5: `access_ok` returns to 1 exactly EXIT_CYCLES + RECOVERY_CYCLES (default 2 + 2) clock edges after `sleep_active` falls.
- R6: `access_go` is 1 only when `chip_sel` is 1 and `access_ok` is 1. As a result, no access passes while entering, sleeping, exiting or recovering, and stored data are preserved.
- R7: If `chip_sel` is sampled high at the clock edge where entry begins (state awake, synchronized request high), `violation` is 1 for the cycle that follows that edge.
- R8: If `chip_sel` is sampled high at an edge during the recovery window, `violation` is 1 for the cycle that follows that edge.
- R9: If `chip_sel` is high while the state is entering, asleep or exiting, or while it is awake with no pending request, `violation` stays 0.
- R10: Once entry has started, it always completes. A request that is released during entry still leads to one cycle of `sleep_active`, followed by the full exit and recovery sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Asynchronous sleep request, 1 = sleep |
| chip_sel | input | 1 | Combined chip-enable, 1 = chip selected |
| sleep_active | output | 1 | 1 while the block is in the sleep state |
| access_ok | output | 1 | 1 when accesses may be performed |
| access_go | output | 1 | Gated access strobe to the storage array |
| violation | output | 1 | One-cycle pulse on a select-protocol violation |

## Verification
The assertions assume that `chip_sel` is a clean synchronous signal with a known value from reset onward. They also assume that `sleep_req` stays at each level long enough for the synchronizer to pass it, which is at least two clock cycles. The bench changes both inputs only on falling edges, so it meets these assumptions. It holds each request level for ten cycles in the sweeps, and for three cycles in the short-pulse case. Because it sweeps a one-cycle select pulse across every cycle of entry and exit, each violation window is hit from both sides.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_ENTER   = 3'd1,
        ST_ASLEEP  = 3'd2,
        ST_EXIT    = 3'd3,
        ST_RECOVER = 3'd4
    } slp_state_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int ENTRY_CYCLES    = 2,
    parameter int EXIT_CYCLES     = 2,
    parameter int RECOVERY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    output slp_state_t state_q
);
    localparam int MAX_A  = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
    localparam int MAX_C  = (MAX_A > RECOVERY_CYCLES) ? MAX_A : RECOVERY_CYCLES;
    localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    slp_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic             phase_done;

    // Last count value of the current timed phase.
    always_comb begin
        unique case (state_q)
            ST_ENTER:   lim_m1 = CNT_W'(ENTRY_CYCLES - 1);
            ST_EXIT:    lim_m1 = CNT_W'(EXIT_CYCLES - 1);
            ST_RECOVER: lim_m1 = CNT_W'(RECOVERY_CYCLES - 1);
            default:    lim_m1 = '0;
        endcase
    end

    assign phase_done = (cnt_q == lim_m1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:   if (req_s)      state_d = ST_ENTER;
            ST_ENTER:   if (phase_done) state_d = ST_ASLEEP;
            ST_ASLEEP:  if (!req_s)     state_d = ST_EXIT;
            ST_EXIT:    if (phase_done) state_d = ST_RECOVER;
            ST_RECOVER: if (phase_done) state_d = ST_AWAKE;
            default:                    state_d = ST_AWAKE;
        endcase
    end

    // State register; the phase counter restarts on every state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/slp_guard.sv
module slp_guard
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slp_state_t state_q,
    input  logic       req_s,
    input  logic       chip_sel,
    output logic       sleep_active,
    output logic       access_ok,
    output logic       access_go,
    output logic       violation
);
    logic bad_sel;

    // Output decode from the state.
    always_comb begin
        sleep_active = 1'b0;
        access_ok    = 1'b0;
        bad_sel      = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                access_ok = 1'b1;
                bad_sel   = chip_sel && req_s;
            end
            ST_ASLEEP:  sleep_active = 1'b1;
            ST_RECOVER: bad_sel = chip_sel;
            default: ;
        endcase
        access_go = chip_sel && access_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) violation <= 1'b0;
        else        violation <= bad_sel;
    end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int ENTRY_CYCLES    = 2,
    parameter int EXIT_CYCLES     = 2,
    parameter int RECOVERY_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic chip_sel,
    output logic sleep_active,
    output logic access_ok,
    output logic access_go,
    output logic violation
);
    logic       req_s;
    slp_state_t state_q;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sleep_req),
        .q     (req_s)
    );

    slp_fsm #(
        .ENTRY_CYCLES    (ENTRY_CYCLES),
        .EXIT_CYCLES     (EXIT_CYCLES),
        .RECOVERY_CYCLES (RECOVERY_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_s   (req_s),
        .state_q (state_q)
    );

    slp_guard u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .req_s        (req_s),
        .chip_sel     (chip_sel),
        .sleep_active (sleep_active),
        .access_ok    (access_ok),
        .access_go    (access_go),
        .violation    (violation)
    );
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
    parameter int ENTRY_CYCLES    = 2,
    parameter int EXIT_CYCLES     = 2,
    parameter int RECOVERY_CYCLES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic chip_sel,
    input logic sleep_active,
    input logic access_ok,
    input logic access_go
    ,input logic violation
);
    // Counts the cycles spent neither awake nor asleep.
    logic [7:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       gap_q <= '0;
        else if (access_ok || sleep_active) gap_q <= '0;
        else if (gap_q != 8'hFF)          gap_q <= gap_q + 8'd1;
    end

    a_r3_entry_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> (gap_q == 8'(ENTRY_CYCLES)));

    a_r5_exit_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok) |-> (gap_q == 8'(EXIT_CYCLES + RECOVERY_CYCLES)));

    a_r6_no_go_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> (!access_go && !access_ok));

    a_r7_viol_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $past(chip_sel));

    a_r9_no_viol_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> !$past(sleep_active));
endmodule

bind slp_ctrl slp_ctrl_chk #(
    .ENTRY_CYCLES    (ENTRY_CYCLES),
    .EXIT_CYCLES     (EXIT_CYCLES),
    .RECOVERY_CYCLES (RECOVERY_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_sel     (chip_sel),
    .sleep_active (sleep_active),
    .access_ok    (access_ok),
    .access_go    (access_go),
    .violation    (violation)
);

// File: tb/slp_ctrl_tb.sv
module slp_ctrl_tb;
    localparam int S = 2;
    localparam int E = 2;
    localparam int X = 2;
    localparam int V = 2;
    localparam int LEN = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic sleep_req;
    logic chip_sel;
    logic sleep_active, access_ok, access_go, violation;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    slp_ctrl #(
        .SYNC_STAGES(S), .ENTRY_CYCLES(E), .EXIT_CYCLES(X), .RECOVERY_CYCLES(V)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_sel(chip_sel),
        .sleep_active(sleep_active), .access_ok(access_ok),
        .access_go(access_go), .violation(violation)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; sleep_req = 1'b0; chip_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 access_ok", access_ok, 1'b1);
        chk("R1 sleep_active", sleep_active, 1'b0);
        chk("R1 violation", violation, 1'b0);

        for (int p = 0; p < LEN; p++) begin
            // Entry with a one-cycle select at cycle p.
            for (int k = 0; k < LEN; k++) begin
                if (k > 0) @(negedge clk);
                if (k == 0) sleep_req = 1'b1;
                chk("R2 access_ok entry", access_ok, 1'(k <= S));
                chk("R3 sleep_active entry", sleep_active, 1'(k >= S + 1 + E));
                if (p == S) chk("R7 violation", violation, 1'(k == S + 1));
                else        chk("R9 violation entry", violation, 1'b0);
                chip_sel = (k == p);
                #1;
                chk("R6 access_go entry", access_go, 1'(chip_sel && (k <= S)));
            end
            @(negedge clk); chip_sel = 1'b0;
            repeat (2) @(negedge clk);
            // Exit with a one-cycle select at cycle p.
            for (int k = 0; k < LEN; k++) begin
                if (k > 0) @(negedge clk);
                if (k == 0) sleep_req = 1'b0;
                chk("R4 sleep_active exit", sleep_active, 1'(k <= S));
                chk("R5 access_ok exit", access_ok, 1'(k >= S + 1 + X + V));
                if (p >= S + 1 + X && p <= S + X + V)
                    chk("R8 violation", violation, 1'(k == p + 1));
                else
                    chk("R9 violation exit", violation, 1'b0);
                chip_sel = (k == p);
                #1;
                chk("R6 access_go exit", access_go, 1'(chip_sel && (k >= S + 1 + X + V)));
            end
            @(negedge clk); chip_sel = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R10: a short request still completes a full cycle.
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0) sleep_req = 1'b1;
            if (k == 3) sleep_req = 1'b0;
            chk("R10 sleep_active pulse", sleep_active, 1'(k == 5));
            chk("R10 access_ok pulse", access_ok, 1'(k <= 2 || k >= 10));
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule